// File: doc/BRIEF.md
# Exception Priority and Vector Unit

This unit sits beside the control path of a 32-bit processor core and decides which pending exception, if any, the core enters next. Each cycle it samples six synchronous exception requests (data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt) and the two interrupt-disable bits. Reset is the seventh source and arrives through the asynchronous reset pin. On the clock edge it picks one winner by a fixed priority, and in the following cycle it presents a one-cycle take strobe with the winner's code, the processor mode to enter, the vector fetch address, the return link and the new interrupt-disable bits.

The vector address is a base plus a per-exception offset. The base is either all zeros or a high base selected by a configuration input. The offset slot between data abort and normal interrupt is reserved and never produced. All outputs are registered. Between takes they keep the values of the last exception taken, so the core can read them at any time after the strobe.

Top module: `exc_vector_unit`

## Requirements
- R1: While `rst_n` is low, `take_o` is 0 at once, without waiting for a clock. On the first rising edge after release, the unit takes reset whatever else is requested: code 0, supervisor mode, vector equal to the selected base, and both disable outputs set to 1.
- R2: Among the sampled requests, the winner is chosen in this order, highest first: data abort, fast interrupt, normal interrupt, prefetch abort, then undefined instruction and software interrupt.
- R3: When undefined instruction and software interrupt are requested together, undefined instruction wins.
- R4: The normal interrupt is ignored while `irq_mask_i` is 1, and the fast interrupt is ignored while `fiq_mask_i` is 1. The other requests are never masked. A masked-out request lets a lower request win, or produces no take at all.
- R5: On a take, `mode_o` encodes the target mode as follows. FIQ mode is 1 and IRQ mode is 2. Supervisor mode is 3 and is used for reset and software interrupt. Abort mode is 4 and is used for both aborts. Undefined mode is 5.
- R6: On a take, `code_o` gives the exception: reset 0, undefined 1, software interrupt 2, prefetch abort 3, data abort 4, normal interrupt 6, fast interrupt 7. With `hivec_i` = 0, `vector_o` is code × 4, so address 0x14 is never produced.
- R7: With `hivec_i` = 1 at the sampling edge, `vector_o` is 0xFFFF0000 plus the same offset.
- R8: On a take, `link_o` equals the `pc_i` sampled at that edge plus 4, modulo 2^32.
- R9: On a take, `irq_mask_o` is 1. `fiq_mask_o` is 1 for reset and fast interrupt; for every other exception it repeats the sampled `fiq_mask_i`.
- R10: `take_o` is 1 for exactly the cycle after an edge at which a winner existed. After an edge with no winner, `take_o` is 0 and all other outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, also the reset exception source |
| hivec_i | input | 1 | Selects the high vector base |
| irq_mask_i | input | 1 | Current normal-interrupt disable bit |
| fiq_mask_i | input | 1 | Current fast-interrupt disable bit |
| pc_i | input | 32 | Current program counter |
| dabt_i | input | 1 | Data abort request |
| fiq_i | input | 1 | Fast interrupt request |
| irq_i | input | 1 | Normal interrupt request |
| pabt_i | input | 1 | Prefetch abort request |
| und_i | input | 1 | Undefined instruction request |
| swi_i | input | 1 | Software interrupt request |
| take_o | output | 1 | One-cycle exception take strobe |
| code_o | output | 3 | Winning exception code |
| mode_o | output | 3 | Target processor mode |
| vector_o | output | 32 | Vector fetch address |
| link_o | output | 32 | Return link value |
| irq_mask_o | output | 1 | Normal-interrupt disable bit to load |
| fiq_mask_o | output | 1 | Fast-interrupt disable bit to load |

## Verification
The hardest case to reach is the reset take, because it happens only on the single edge after `rst_n` is released. The bench also has to show that reset wins over other requests on that edge. To do this, the stimulus holds data abort and the fast interrupt high while it releases reset. It does the same again in the middle of the run with the high base selected. A second hard case is a masked interrupt that falls through to a lower request, or to no take at all. The bench covers it by pairing each disable bit with the requests just below it and checking that the held outputs do not change.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
    localparam int ADDR_W = 32;

    typedef enum logic [2:0] {
        EXC_RESET = 3'd0,
        EXC_UND   = 3'd1,
        EXC_SWI   = 3'd2,
        EXC_PABT  = 3'd3,
        EXC_DABT  = 3'd4,
        EXC_RSVD  = 3'd5,
        EXC_IRQ   = 3'd6,
        EXC_FIQ   = 3'd7
    } exc_code_e;

    typedef enum logic [2:0] {
        MODE_NONE = 3'd0,
        MODE_FIQ  = 3'd1,
        MODE_IRQ  = 3'd2,
        MODE_SVC  = 3'd3,
        MODE_ABT  = 3'd4,
        MODE_UND  = 3'd5
    } mode_e;

    typedef struct packed {
        logic              take;
        exc_code_e         code;
        mode_e             mode;
        logic [ADDR_W-1:0] vec;
        logic [ADDR_W-1:0] link;
        logic              i_dis;
        logic              f_dis;
        logic              rst_pend;
    } evu_state_t;
endpackage

// File: rtl/exc_prio_arb.sv
`timescale 1ns/1ps
module exc_prio_arb
    import exc_pkg::*;
(
    input  logic      rst_pend_i,
    input  logic      irq_mask_i,
    input  logic      fiq_mask_i,
    input  logic      dabt_i,
    input  logic      fiq_i,
    input  logic      irq_i,
    input  logic      pabt_i,
    input  logic      und_i,
    input  logic      swi_i,
    output logic      hit_o,
    output exc_code_e code_o
);
    logic fiq_live;
    logic irq_live;

    assign fiq_live = fiq_i & ~fiq_mask_i;
    assign irq_live = irq_i & ~irq_mask_i;

    always_comb begin
        hit_o  = 1'b1;
        code_o = EXC_RESET;
        if (rst_pend_i)    code_o = EXC_RESET;
        else if (dabt_i)   code_o = EXC_DABT;
        else if (fiq_live) code_o = EXC_FIQ;
        else if (irq_live) code_o = EXC_IRQ;
        else if (pabt_i)   code_o = EXC_PABT;
        else if (und_i)    code_o = EXC_UND;
        else if (swi_i)    code_o = EXC_SWI;
        else               hit_o  = 1'b0;
    end

    always_comb begin
        if (hit_o) assert (code_o != EXC_RSVD) else $error("arbiter chose reserved code");
    end
endmodule

// File: rtl/exc_vec_gen.sv
`timescale 1ns/1ps
module exc_vec_gen
    import exc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] HI_BASE = 32'hFFFF_0000
) (
    input  exc_code_e         code_i,
    input  logic              hivec_i,
    output logic [ADDR_W-1:0] vec_o,
    output mode_e             mode_o,
    output logic              f_force_o
);
    localparam int OFS_W = 5;

    logic [ADDR_W-1:0] base;
    logic [OFS_W-1:0]  ofs;

    assign base  = hivec_i ? HI_BASE : '0;
    assign ofs   = {code_i, 2'b00};
    assign vec_o = base | {{(ADDR_W-OFS_W){1'b0}}, ofs};

    always_comb begin
        f_force_o = 1'b0;
        unique case (code_i)
            EXC_RESET: begin mode_o = MODE_SVC; f_force_o = 1'b1; end
            EXC_SWI:   mode_o = MODE_SVC;
            EXC_UND:   mode_o = MODE_UND;
            EXC_PABT,
            EXC_DABT:  mode_o = MODE_ABT;
            EXC_IRQ:   mode_o = MODE_IRQ;
            EXC_FIQ:   begin mode_o = MODE_FIQ; f_force_o = 1'b1; end
            default:   mode_o = MODE_NONE;
        endcase
    end
endmodule

// File: rtl/exc_vector_unit.sv
`timescale 1ns/1ps
module exc_vector_unit
    import exc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] HI_BASE = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hivec_i,
    input  logic              irq_mask_i,
    input  logic              fiq_mask_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              dabt_i,
    input  logic              fiq_i,
    input  logic              irq_i,
    input  logic              pabt_i,
    input  logic              und_i,
    input  logic              swi_i,
    output logic              take_o,
    output logic [2:0]        code_o,
    output logic [2:0]        mode_o,
    output logic [ADDR_W-1:0] vector_o,
    output logic [ADDR_W-1:0] link_o,
    output logic              irq_mask_o,
    output logic              fiq_mask_o
);
    localparam logic [ADDR_W-1:0] LINK_ADJ = ADDR_W'(4);

    evu_state_t        s_d, s_q;
    logic              arb_hit;
    exc_code_e         arb_code;
    logic [ADDR_W-1:0] gen_vec;
    mode_e             gen_mode;
    logic              gen_f_force;

    exc_prio_arb i_arb (
        .rst_pend_i (s_q.rst_pend),
        .irq_mask_i (irq_mask_i),
        .fiq_mask_i (fiq_mask_i),
        .dabt_i     (dabt_i),
        .fiq_i      (fiq_i),
        .irq_i      (irq_i),
        .pabt_i     (pabt_i),
        .und_i      (und_i),
        .swi_i      (swi_i),
        .hit_o      (arb_hit),
        .code_o     (arb_code)
    );

    exc_vec_gen #(.HI_BASE(HI_BASE)) i_vgen (
        .code_i    (arb_code),
        .hivec_i   (hivec_i),
        .vec_o     (gen_vec),
        .mode_o    (gen_mode),
        .f_force_o (gen_f_force)
    );

    always_comb begin
        s_d          = s_q;
        s_d.take     = 1'b0;
        s_d.rst_pend = 1'b0;
        if (arb_hit) begin
            s_d.take  = 1'b1;
            s_d.code  = arb_code;
            s_d.mode  = gen_mode;
            s_d.vec   = gen_vec;
            s_d.link  = pc_i + LINK_ADJ;
            s_d.i_dis = 1'b1;
            s_d.f_dis = gen_f_force | fiq_mask_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.take     <= 1'b0;
            s_q.code     <= EXC_RESET;
            s_q.mode     <= MODE_SVC;
            s_q.vec      <= '0;
            s_q.link     <= '0;
            s_q.i_dis    <= 1'b1;
            s_q.f_dis    <= 1'b1;
            s_q.rst_pend <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign take_o     = s_q.take;
    assign code_o     = s_q.code;
    assign mode_o     = s_q.mode;
    assign vector_o   = s_q.vec;
    assign link_o     = s_q.link;
    assign irq_mask_o = s_q.i_dis;
    assign fiq_mask_o = s_q.f_dis;

    // R6: the reserved slot never reaches the vector output
    p_no_reserved_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (vector_o[4:0] != 5'h14));

    // R4: a taken normal interrupt was enabled at its sampling edge
    p_irq_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && code_o == 3'd6) |-> !$past(irq_mask_i));

    // R4: a taken fast interrupt was enabled at its sampling edge
    p_fiq_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && code_o == 3'd7) |-> !$past(fiq_mask_i));

    // R2: data abort beats everything except a pending reset
    p_dabt_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && $past(dabt_i) && !$past(s_q.rst_pend)) |-> (code_o == 3'd4));

    // R8: link follows the sampled program counter
    p_link_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (link_o == $past(pc_i) + LINK_ADJ));

    // R9: every take disables normal interrupts
    p_irq_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> irq_mask_o);

    // R10: with no take the vector holds
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> $stable(vector_o));
endmodule

// File: tb/test_exc_vector_unit.sv
`timescale 1ns/1ps
module test_exc_vector_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hivec, imask, fmask;
    logic [31:0] pc;
    logic        dabt, fiq, irq, pabt, und, swi;
    logic        take;
    logic [2:0]  code, mode;
    logic [31:0] vector, link;
    logic        imask_o, fmask_o;

    int n_cmp = 0;
    int n_err = 0;

    typedef struct {
        logic        take;
        logic [2:0]  code;
        logic [2:0]  mode;
        logic [31:0] vec;
        logic [31:0] link;
        logic        iset;
        logic        fset;
        string       tag;
    } exp_t;

    exp_t scb[$];
    exp_t held;

    always #2 clk = ~clk;

    exc_vector_unit i_exc_vector_unit (
        .clk(clk), .rst_n(rst_n), .hivec_i(hivec), .irq_mask_i(imask), .fiq_mask_i(fmask),
        .pc_i(pc), .dabt_i(dabt), .fiq_i(fiq), .irq_i(irq), .pabt_i(pabt), .und_i(und),
        .swi_i(swi), .take_o(take), .code_o(code), .mode_o(mode), .vector_o(vector),
        .link_o(link), .irq_mask_o(imask_o), .fiq_mask_o(fmask_o)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [2:0] mode_of(input logic [2:0] c);
        case (c)
            3'd0, 3'd2: return 3'd3;
            3'd1:       return 3'd5;
            3'd3, 3'd4: return 3'd4;
            3'd6:       return 3'd2;
            default:    return 3'd1;
        endcase
    endfunction

    // driver: drives one cycle of stimulus and queues the expected result
    task automatic drive(input string tag, input logic rst_first, input logic hv,
                         input logic im, input logic fm, input logic [31:0] p,
                         input logic da, input logic fq, input logic iq,
                         input logic pa, input logic ud, input logic sw);
        exp_t e;
        logic win;
        logic [2:0] c;
        @(negedge clk);
        hivec = hv; imask = im; fmask = fm; pc = p;
        dabt = da; fiq = fq; irq = iq; pabt = pa; und = ud; swi = sw;
        if (rst_first) rst_n = 1'b1;
        win = 1'b1;
        c = 3'd0;
        if (rst_first)        c = 3'd0;
        else if (da)          c = 3'd4;
        else if (fq && !fm)   c = 3'd7;
        else if (iq && !im)   c = 3'd6;
        else if (pa)          c = 3'd3;
        else if (ud)          c = 3'd1;
        else if (sw)          c = 3'd2;
        else                  win = 1'b0;
        if (win) begin
            e.take = 1'b1;
            e.code = c;
            e.mode = mode_of(c);
            e.vec  = (hv ? 32'hFFFF_0000 : 32'h0) + {27'd0, c, 2'b00};
            e.link = p + 32'd4;
            e.iset = 1'b1;
            e.fset = (c == 3'd0 || c == 3'd7) ? 1'b1 : fm;
            held = e;
        end else begin
            e = held;
            e.take = 1'b0;
        end
        e.tag = tag;
        scb.push_back(e);
    endtask

    // monitor: compares one queued item after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (scb.size() > 0) begin
                exp_t e;
                e = scb.pop_front();
                check(e.tag, "take", {31'd0, take}, {31'd0, e.take});
                check(e.tag, "code", {29'd0, code}, {29'd0, e.code});
                check(e.tag, "mode", {29'd0, mode}, {29'd0, e.mode});
                check(e.tag, "vector", vector, e.vec);
                check(e.tag, "link", link, e.link);
                check(e.tag, "imask", {31'd0, imask_o}, {31'd0, e.iset});
                check(e.tag, "fmask", {31'd0, fmask_o}, {31'd0, e.fset});
                if (take) check("R6", "no 0x14 slot", {31'd0, vector[4:0] == 5'h14}, 32'd0);
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    endtask

    initial begin
        #800000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        hivec = 0; imask = 0; fmask = 0; pc = 32'h100;
        dabt = 0; fiq = 0; irq = 0; pabt = 0; und = 0; swi = 0;
        repeat (3) @(posedge clk);
        #1 check("R1", "take in reset", {31'd0, take}, 32'd0);
        // R1: reset release beats data abort and fast interrupt
        drive("R1", 1'b1, 0, 0, 0, 32'h0000_1000, 1, 1, 0, 0, 0, 0);
        drive("R10", 0, 0, 0, 0, 32'h0000_2000, 0, 0, 0, 0, 0, 0);
        drive("R2", 0, 0, 0, 0, 32'h0000_3000, 1, 1, 1, 1, 1, 1);
        drive("R2", 0, 0, 0, 0, 32'h0000_3004, 0, 1, 1, 1, 1, 1);
        drive("R9", 0, 0, 0, 0, 32'h0000_3008, 0, 0, 1, 1, 1, 1);
        drive("R2", 0, 0, 0, 1, 32'h0000_300C, 0, 0, 0, 1, 1, 1);
        drive("R3", 0, 0, 0, 0, 32'h0000_3010, 0, 0, 0, 0, 1, 1);
        drive("R5", 0, 0, 0, 1, 32'h0000_3014, 0, 0, 0, 0, 0, 1);
        drive("R10", 0, 0, 0, 0, 32'h0000_3018, 0, 0, 0, 0, 0, 0);
        drive("R4", 0, 0, 1, 0, 32'h0000_4000, 0, 0, 1, 1, 0, 0);
        drive("R4", 0, 0, 1, 0, 32'h0000_4004, 0, 0, 1, 0, 0, 0);
        drive("R4", 0, 0, 0, 1, 32'h0000_4008, 0, 1, 1, 0, 0, 0);
        drive("R4", 0, 0, 1, 1, 32'h0000_400C, 0, 1, 1, 0, 0, 0);
        drive("R4", 0, 0, 1, 1, 32'h0000_4010, 1, 1, 1, 0, 0, 0);
        drive("R7", 0, 1, 0, 0, 32'h0000_5000, 1, 0, 0, 0, 0, 0);
        drive("R7", 0, 1, 0, 0, 32'h0000_5004, 0, 0, 0, 0, 1, 0);
        drive("R7", 0, 1, 0, 0, 32'h0000_5008, 0, 1, 0, 0, 0, 0);
        drive("R8", 0, 0, 0, 0, 32'hFFFF_FFFC, 0, 0, 1, 0, 0, 0);
        drive("R10", 0, 0, 0, 0, 32'h0000_6000, 0, 0, 0, 0, 0, 0);
        @(posedge clk);
        #1;
        // R1: asynchronous reset takes effect between edges
        @(negedge clk);
        dabt = 1; fiq = 1;
        #1 rst_n = 1'b0;
        #0.5 check("R1", "async take clear", {31'd0, take}, 32'd0);
        @(posedge clk);
        drive("R1", 1'b1, 1, 0, 0, 32'h0000_7000, 1, 1, 1, 0, 0, 0);
        drive("R10", 0, 1, 0, 0, 32'h0000_7004, 0, 0, 0, 0, 0, 0);
        @(posedge clk);
        @(posedge clk);
        #1;
        finish_run();
    end
endmodule